// File: doc/BRIEF.md
# Latched-Mode Scanline Timing Generator

This block produces line and frame timing for a display panel. It is advanced by a pixel-clock enable. A 12-bit horizontal counter runs from zero up to a programmed line total and then wraps. Six absolute compare points are checked against the count. When the count equals a point, the controller latches into a new output mode on that step: sync, back porch, left border, image, right border or front porch. The modes are not derived from porch widths; each mode stays in force until another compare point latches a new one.

A vertical counter advances once per completed line and wraps after a programmed vertical total. From the latched mode the block drives a sync output, a pixel-request enable and a border select. While a border mode is active it also presents a programmed fill colour. Two sticky interrupt flags, one for the end of each line and one for the end of each frame, sit in a status word. Software clears them by writing ones to them.

Top module: `dtg_timing_top`

## Requirements
- R1: On every cycle with `pix_en` high, `hcount_o` advances by one, or returns to 0 when it is at or above `h_total`. With `pix_en` low it holds its value. The line rate is therefore the pixel rate divided by (`h_total`+1).
- R2: `vcount_o` advances only on a pixel step where `hcount_o` is at or above `h_total`. On that step it returns to 0 when it is at or above `v_total`. The frame therefore spans (`h_total`+1)×(`v_total`+1) pixel steps.
- R3: The mode codes on `mode_o` are 0 sync, 1 back porch, 2 left border, 3 image, 4 right border and 5 front porch. On a pixel step where `hcount_o` equals a compare point, `mode_o` takes that point's mode from the next cycle on. With no match, or with `pix_en` low, the mode holds.
- R4: When several points match on the same step, the highest code wins. Front porch wins over right border, which wins over image, then left border, then back porch, then sync.
- R5: If the back-porch point equals the sync point, sync mode is never entered and `hsync_o` stays low.
- R6: A left-border match has effect only while the mode is back porch. When the back-porch event wins and the left-border point is below the back-porch point, the mode goes straight to left border, so the back-porch period is zero.
- R7: `h_image_pts` carries the image-start point in bits 11:0 and the image-end (right border) point in bits 27:16. Bits 15:12 and 31:28 are ignored.
- R8: `hsync_o` is high exactly while the mode is sync. `pix_req_o` is high exactly while the mode is image. `border_sel_o` is high exactly while the mode is left or right border.
- R9: `border_rgb_o` equals `fill_color[23:0]` while `border_sel_o` is high and is zero otherwise. Bits 31:24 of `fill_color` are ignored.
- R10: Status bit 16 is set on every line-end step and bit 17 on every frame-end step. Writing 1 to either bit clears it. A set in the same cycle wins over a clear. All other status bits read 0.
- R11: After reset both counters are 0, the mode is front porch (5) and the status word is 0. Reset is asserted asynchronously and released through two synchronising flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable, one step per high cycle |
| h_total | input | 12 | Last value of the horizontal count |
| h_sync_pt | input | 12 | Compare point that enters sync |
| h_back_pt | input | 12 | Compare point that enters back porch |
| h_lbord_pt | input | 12 | Compare point that enters left border |
| h_image_pts | input | 32 | Image start [11:0], image end [27:16] |
| h_front_pt | input | 12 | Compare point that enters front porch |
| v_total | input | 12 | Last value of the line count |
| fill_color | input | 32 | Border colour in [23:0] |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Write-one-to-clear mask |
| mode_o | output | 3 | Latched mode code |
| hsync_o | output | 1 | Sync pulse |
| pix_req_o | output | 1 | Pixel-request enable |
| border_sel_o | output | 1 | Border colour select |
| border_rgb_o | output | 24 | Border colour or zero |
| hcount_o | output | 12 | Horizontal count |
| vcount_o | output | 12 | Line count |
| stat_o | output | 32 | Status word |

## Verification
The assertions assume that `pix_en` is a plain level and that the configuration inputs change only between test phases, never as part of a timing rule. The assertions on holding and wrapping do not depend on the compare points being ordered, so they still hold when the points coincide or are out of order. The stimulus deliberately sets up coincident points, a back-porch point equal to the sync point, and a left-border point below the back-porch point. It also runs with a gapped pixel enable and places clear writes at arbitrary times, including cycles where a flag is being set.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int CNT_W = 12;
  localparam int RGB_W = 24;
  localparam int N_PTS = 6;
  localparam int HB_BIT = 16;
  localparam int VB_BIT = 17;

  typedef enum logic [2:0] {
    M_SYNC  = 3'd0,
    M_BACK  = 3'd1,
    M_LBORD = 3'd2,
    M_IMAGE = 3'd3,
    M_RBORD = 3'd4,
    M_FRONT = 3'd5
  } dtg_mode_e;
endpackage

// File: rtl/dtg_hcounter.sv
module dtg_hcounter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [CW-1:0] h_total,
  output logic [CW-1:0] hcount,
  output logic          line_end
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign line_end = pix_en && (cnt_q >= h_total);

  always_comb begin
    cnt_d = cnt_q;
    if (pix_en) begin
      if (cnt_q >= h_total) cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hcount = cnt_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(hcount));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcount == '0));
endmodule

// File: rtl/dtg_vcounter.sv
module dtg_vcounter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic [CW-1:0] v_total,
  output logic [CW-1:0] vcount,
  output logic          frame_end
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign frame_end = line_end && (cnt_q >= v_total);

  always_comb begin
    cnt_d = cnt_q;
    if (line_end) begin
      if (cnt_q >= v_total) cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign vcount = cnt_q;

  assert_vhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcount));
  assert_vwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (vcount == '0));
endmodule

// File: rtl/dtg_mode_latch.sv
module dtg_mode_latch
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_en,
  input  logic [CW-1:0]          hcount,
  input  logic [N_PTS-1:0][CW-1:0] pts,
  output dtg_mode_e              mode
);
  dtg_mode_e           mode_q, mode_d, winner;
  logic [N_PTS-1:0]    hit, hit_eff;
  logic                any_hit;

  // one comparator per compare point, indexed by the mode it enters
  for (genvar g = 0; g < N_PTS; g++) begin : g_cmp
    assign hit[g] = (hcount == pts[g]);
  end

  always_comb begin
    hit_eff = hit;
    // left border only takes the controller out of back porch
    hit_eff[M_LBORD] = hit[M_LBORD] && (mode_q == M_BACK);
    any_hit = |hit_eff;
    winner  = mode_q;
    // ascending scan: the highest code that fires wins (R4)
    for (int i = 0; i < N_PTS; i++) begin
      if (hit_eff[i]) winner = dtg_mode_e'(3'(i));
    end
    // zero-length back porch when the border point lies below it
    if (any_hit && winner == M_BACK && pts[M_LBORD] < pts[M_BACK])
      winner = M_LBORD;
  end

  always_comb begin
    mode_d = mode_q;
    if (pix_en) mode_d = winner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_FRONT;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(mode));
  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= M_FRONT);
  assert_front_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hcount == pts[M_FRONT]) |=> (mode == M_FRONT));
  assert_no_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && hcount == pts[M_SYNC] && pts[M_BACK] == pts[M_SYNC])
      |=> (mode != M_SYNC));
endmodule

// File: rtl/dtg_irq_status.sv
module dtg_irq_status
  import dtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_set,
  input  logic        frame_set,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] status
);
  logic [1:0] flag_q, flag_d, set_v, clr_v;

  assign set_v = {frame_set, line_set};
  assign clr_v = wr ? {wdata[VB_BIT], wdata[HB_BIT]} : 2'b00;

  always_comb begin
    // a set in the same cycle overrides the acknowledge
    flag_d = set_v | (flag_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    status         = '0;
    status[HB_BIT] = flag_q[0];
    status[VB_BIT] = flag_q[1];
  end

  assert_hset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_set |=> status[HB_BIT]);
  assert_hclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[HB_BIT] && !line_set) |=> !status[HB_BIT]);
  assert_vclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[VB_BIT] && !frame_set) |=> !status[VB_BIT]);
endmodule

// File: rtl/dtg_timing_top.sv
module dtg_timing_top
  import dtg_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int CLRW = RGB_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic [CW-1:0]   h_total,
  input  logic [CW-1:0]   h_sync_pt,
  input  logic [CW-1:0]   h_back_pt,
  input  logic [CW-1:0]   h_lbord_pt,
  input  logic [31:0]     h_image_pts,
  input  logic [CW-1:0]   h_front_pt,
  input  logic [CW-1:0]   v_total,
  input  logic [31:0]     fill_color,
  input  logic            stat_wr,
  input  logic [31:0]     stat_wdata,
  output logic [2:0]      mode_o,
  output logic            hsync_o,
  output logic            pix_req_o,
  output logic            border_sel_o,
  output logic [CLRW-1:0] border_rgb_o,
  output logic [CW-1:0]   hcount_o,
  output logic [CW-1:0]   vcount_o,
  output logic [31:0]     stat_o
);
  localparam int HI_LSB = 16;

  logic       rs1_q, rs2_q, rst_int_n;
  logic       line_end, frame_end;
  logic [N_PTS-1:0][CW-1:0] pts;
  dtg_mode_e  mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  always_comb begin
    pts          = '0;
    pts[M_SYNC]  = h_sync_pt;
    pts[M_BACK]  = h_back_pt;
    pts[M_LBORD] = h_lbord_pt;
    pts[M_IMAGE] = h_image_pts[CW-1:0];
    pts[M_RBORD] = h_image_pts[HI_LSB+CW-1:HI_LSB];
    pts[M_FRONT] = h_front_pt;
  end

  dtg_hcounter #(.CW(CW)) u_hcnt (
    .clk(clk), .rst_n(rst_int_n), .pix_en(pix_en), .h_total(h_total),
    .hcount(hcount_o), .line_end(line_end)
  );

  dtg_vcounter #(.CW(CW)) u_vcnt (
    .clk(clk), .rst_n(rst_int_n), .line_end(line_end), .v_total(v_total),
    .vcount(vcount_o), .frame_end(frame_end)
  );

  dtg_mode_latch #(.CW(CW)) u_mode (
    .clk(clk), .rst_n(rst_int_n), .pix_en(pix_en), .hcount(hcount_o),
    .pts(pts), .mode(mode)
  );

  dtg_irq_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .line_set(line_end), .frame_set(frame_end),
    .wr(stat_wr), .wdata(stat_wdata), .status(stat_o)
  );

  assign mode_o       = mode;
  assign hsync_o      = (mode == M_SYNC);
  assign pix_req_o    = (mode == M_IMAGE);
  assign border_sel_o = (mode == M_LBORD) || (mode == M_RBORD);
  assign border_rgb_o = border_sel_o ? fill_color[CLRW-1:0] : '0;

  assert_outs_excl_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({hsync_o, pix_req_o, border_sel_o}));
  assert_rgb_zero_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !border_sel_o |-> (border_rgb_o == '0));
endmodule

// File: tb/dtg_timing_top_test.sv
module dtg_timing_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [11:0] h_total = 12'd23, h_sync_pt = 12'd0, h_back_pt = 12'd3;
  logic [11:0] h_lbord_pt = 12'd5, h_front_pt = 12'd21, v_total = 12'd4;
  logic [31:0] h_image_pts = 32'hA012_5008;
  logic [31:0] fill_color = 32'hDEAD_BEEF;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [2:0]  mode_o;
  logic        hsync_o, pix_req_o, border_sel_o;
  logic [23:0] border_rgb_o;
  logic [11:0] hcount_o, vcount_o;
  logic [31:0] stat_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtg_timing_top uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_total(h_total),
    .h_sync_pt(h_sync_pt), .h_back_pt(h_back_pt), .h_lbord_pt(h_lbord_pt),
    .h_image_pts(h_image_pts), .h_front_pt(h_front_pt), .v_total(v_total),
    .fill_color(fill_color), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .mode_o(mode_o), .hsync_o(hsync_o), .pix_req_o(pix_req_o),
    .border_sel_o(border_sel_o), .border_rgb_o(border_rgb_o),
    .hcount_o(hcount_o), .vcount_o(vcount_o), .stat_o(stat_o)
  );

  // behavioural reference state
  int m_h, m_v, m_mode, m_s1, m_s2;
  bit m_hf, m_vf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      m_h = 0; m_v = 0; m_mode = 5; m_hf = 0; m_vf = 0;
    end else begin
      if (m_s2 == 0) begin
        m_h = 0; m_v = 0; m_mode = 5; m_hf = 0; m_vf = 0;
      end else begin
        int nm;
        bit le, fe, fired;
        int img_s, img_e;
        img_s = int'(h_image_pts[11:0]);
        img_e = int'(h_image_pts[27:16]);
        nm = m_mode; fired = 0;
        if (m_h == h_front_pt)                      begin nm = 5; fired = 1; end
        else if (m_h == img_e)                      begin nm = 4; fired = 1; end
        else if (m_h == img_s)                      begin nm = 3; fired = 1; end
        else if (m_h == h_lbord_pt && m_mode == 1)  begin nm = 2; fired = 1; end
        else if (m_h == h_back_pt)                  begin nm = 1; fired = 1; end
        else if (m_h == h_sync_pt)                  begin nm = 0; fired = 1; end
        if (fired && nm == 1 && h_lbord_pt < h_back_pt) nm = 2;
        le = pix_en && (m_h >= h_total);
        fe = le && (m_v >= v_total);
        if (pix_en) begin
          m_mode = nm;
          m_h = (m_h >= h_total) ? 0 : m_h + 1;
        end
        if (le) m_v = (m_v >= v_total) ? 0 : m_v + 1;
        m_hf = le | (m_hf & !(stat_wr && stat_wdata[16]));
        m_vf = fe | (m_vf & !(stat_wr && stat_wdata[17]));
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  int sync_seen, back_seen, bord_seen;

  // compare everything against the model, then apply next stimulus
  task automatic step(bit en, bit wr, logic [31:0] wd);
    int exp_rgb;
    @(negedge clk);
    chk("R1", "hcount", int'(hcount_o), m_h);
    chk("R2", "vcount", int'(vcount_o), m_v);
    chk("R3", "mode", int'(mode_o), m_mode);
    chk("R8", "hsync", int'(hsync_o), int'(m_mode == 0));
    chk("R8", "pix_req", int'(pix_req_o), int'(m_mode == 3));
    chk("R8", "border_sel", int'(border_sel_o), int'(m_mode == 2 || m_mode == 4));
    exp_rgb = (m_mode == 2 || m_mode == 4) ? int'(fill_color[23:0]) : 0;
    chk("R9", "border_rgb", int'(border_rgb_o), exp_rgb);
    chk("R10", "status", int'(stat_o), (int'(m_vf) << 17) | (int'(m_hf) << 16));
    if (hsync_o) sync_seen++;
    if (mode_o == 3'd1) back_seen++;
    if (border_sel_o) bord_seen++;
    pix_en = en; stat_wr = wr; stat_wdata = wd;
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      bit en, wr;
      logic [31:0] wd;
      en = (gap == 0) ? 1'b1 : (($urandom % gap) != 0);
      wr = (($urandom % 9) == 0);
      wd = {$urandom} & 32'hFFFF_FFFF;
      step(en, wr, wd);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state visible while the release synchroniser runs
    @(negedge clk);
    chk("R11", "reset hcount", int'(hcount_o), 0);
    chk("R11", "reset vcount", int'(vcount_o), 0);
    chk("R11", "reset mode", int'(mode_o), 5);
    chk("R11", "reset status", int'(stat_o), 0);
    // R1 R2 R3 R7 R9: normal line, packed image points with junk bits
    run(400, 0);
    run(400, 3);                           // gapped pixel enable
    chk("R7", "image reached", int'(bord_seen > 0), 1);
    // R10: full acknowledge with enable held off
    step(1'b0, 1'b1, 32'h0003_0000);
    step(1'b0, 1'b0, 32'h0);
    chk("R10", "cleared", int'(stat_o), 0);
    // R5: back-porch point equals sync point
    h_sync_pt = 12'd2; h_back_pt = 12'd2; sync_seen = 0;
    run(300, 0);
    chk("R5", "sync never entered", sync_seen, 0);
    // R6: left-border point below back-porch point
    h_sync_pt = 12'd0; h_back_pt = 12'd4; h_lbord_pt = 12'd1;
    run(50, 0); back_seen = 0;
    run(300, 2);
    chk("R6", "back porch length zero", back_seen, 0);
    // R4: coincident points; image beats left border, front beats right border
    h_back_pt = 12'd3; h_lbord_pt = 12'd6;
    h_image_pts = 32'h300F_7006; h_front_pt = 12'd15;
    fill_color = 32'h1234_5678;
    run(50, 0); bord_seen = 0;
    run(300, 0);
    chk("R4", "no border under coincidence", bord_seen, 0);
    // R9: border colour with top byte ignored, shorter frame
    h_image_pts = 32'h0012_0008; h_lbord_pt = 12'd5; h_front_pt = 12'd21;
    v_total = 12'd1; fill_color = 32'hFF00_00A5;
    run(400, 4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule